// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in a word-addressed memory. A requester hands it a virtual address together with the word address of the root table. The walker fetches one root entry, checks that the second-level table it points to exists, fetches one second-level (leaf) entry, checks that the page is present and may be read, and returns either the physical address or a fault code.

The virtual address is split into three fields. Bits 31:24 select a root entry, bits 23:12 select a leaf entry within the table named by that root entry, and bits 11:0 pass through unchanged as the page offset. A root entry carries a table base in bits 31:12 and a valid flag in bit 0. A leaf entry carries a frame number in bits 31:12, a valid flag in bit 0 and a read-allow flag in bit 1. Only one translation is in progress at a time. Filling missing tables or pages, and keeping any copy of entries, is left to the surrounding system.

Top module: `xlate_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_req` is 0.
- R2: The first memory read of a walk goes to word address `top_base + vaddr[31:24]` (root index zero-extended, 32-bit sum), using the `top_base` value present when the request was accepted.
- R3: The second memory read goes to word address `{root_entry[31:12], 12'b0} + vaddr[23:12]`.
- R4: A root entry with bit 0 clear ends the walk after a single memory read with status 2'b01 (table fault) and `rsp_paddr` equal to zero.
- R5: A leaf entry with bit 0 clear ends the walk with status 2'b10 (page fault) and `rsp_paddr` equal to zero.
- R6: A leaf entry with bit 0 set but bit 1 clear ends the walk with status 2'b10 and `rsp_paddr` equal to zero.
- R7: A leaf entry with bits 0 and 1 set ends the walk with status 2'b00 and `rsp_paddr = {leaf_entry[31:12], vaddr[11:0]}`.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response is taken; `req_valid` seen in that interval has no effect on the memory reads or on the response.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_paddr` and `rsp_status` hold their values.
- R10: `mem_rd_req` is a one-cycle pulse, and no new read is issued before the data of the previous one has returned with `mem_rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_vaddr | input | 32 | Virtual address to translate |
| top_base | input | 32 | Word address of the root table, sampled with the request |
| mem_rd_req | output | 1 | One-cycle read request to the table memory |
| mem_rd_addr | output | 32 | Word address of the read |
| mem_rd_valid | input | 1 | Read data is present this cycle |
| mem_rd_data | input | 32 | Entry returned by the memory |
| rsp_valid | output | 1 | Translation result is present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_status | output | 2 | 00 ok, 01 table fault, 10 page fault |

## Verification
The assertions rely on the memory accepting every read request in the cycle it is raised and answering it with exactly one `mem_rd_valid` pulse, never unprompted and never for two reads at once. The bench's memory model answers only a recorded outstanding read, after a programmable delay of zero or more cycles, and counts any read that arrives while one is pending. Requests are driven only through the handshake, and the response is held off for several cycles in some walks so that the hold rule is exercised with a slow requester.

// File: rtl/xlate_pkg.sv
// Package: shared types and entry-layout constants for the translation walker.
// Assumes a 32-bit entry with flags in the low bits and a base/frame above them.
package xlate_pkg;

    // Result code returned with every response.
    typedef enum logic [1:0] {
        XS_OK       = 2'b00,
        XS_NO_TABLE = 2'b01,
        XS_NO_PAGE  = 2'b10
    } xlate_status_e;

    // Walk sequence; only one walk is in flight.
    typedef enum logic [2:0] {
        WS_IDLE      = 3'd0,
        WS_READ_TOP  = 3'd1,
        WS_WAIT_TOP  = 3'd2,
        WS_READ_LEAF = 3'd3,
        WS_WAIT_LEAF = 3'd4,
        WS_DONE      = 3'd5
    } walk_state_e;

    // Flag positions inside an entry.
    localparam int unsigned VALID_BIT = 0;
    localparam int unsigned RDOK_BIT  = 1;

endpackage

// File: rtl/xlate_addr_gen.sv
// Module: forms the word address of the next table read.
// Assumes the second-level table base is aligned to 2**OFF_W words, so the
// leaf index is added to the base shifted up by OFF_W.
module xlate_addr_gen #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned TOP_W  = 8,
    parameter int unsigned LEAF_W = 12,
    parameter int unsigned OFF_W  = 12,
    localparam int unsigned BASE_W = VA_W - OFF_W
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [VA_W-1:0]   root_base,
    input  logic [BASE_W-1:0] table_base,
    input  logic              use_leaf,
    output logic [VA_W-1:0]   rd_addr,
    output logic [OFF_W-1:0]  page_off
);

    logic [TOP_W-1:0]  top_idx;
    logic [LEAF_W-1:0] leaf_idx;
    logic [VA_W-1:0]   top_word;
    logic [VA_W-1:0]   leaf_word;

    // Split the virtual address into its three fields.
    always_comb begin
        top_idx  = vaddr[VA_W-1 -: TOP_W];
        leaf_idx = vaddr[OFF_W +: LEAF_W];
        page_off = vaddr[OFF_W-1:0];
    end

    // Compute both candidate read addresses and pick the one for this stage.
    always_comb begin
        top_word  = root_base + {{(VA_W-TOP_W){1'b0}}, top_idx};
        leaf_word = {table_base, {OFF_W{1'b0}}} + {{(VA_W-LEAF_W){1'b0}}, leaf_idx};
        rd_addr   = use_leaf ? leaf_word : top_word;
    end

endmodule

// File: rtl/xlate_pte_check.sv
// Module: decodes a fetched entry into its flags and base/frame field.
// Assumes flags sit at VALID_BIT and RDOK_BIT; REQUIRE_RD selects whether
// the leaf check also demands the read-allow flag.
module xlate_pte_check #(
    parameter int unsigned ENT_W      = 32,
    parameter int unsigned OFF_W      = 12,
    parameter bit          REQUIRE_RD = 1'b1,
    localparam int unsigned BASE_W = ENT_W - OFF_W
) (
    input  logic [ENT_W-1:0]  entry,
    output logic              is_valid,
    output logic              leaf_usable,
    output logic [BASE_W-1:0] base_field
);
    import xlate_pkg::*;

    logic unused_flag_bits;

    // Extract the common fields.
    always_comb begin
        is_valid   = entry[VALID_BIT];
        base_field = entry[ENT_W-1:OFF_W];
    end

    assign unused_flag_bits = ^entry[OFF_W-1:RDOK_BIT+1];

    // Leaf usability: valid, and readable when the read check is built in.
    generate
        if (REQUIRE_RD) begin : g_rd_check
            assign leaf_usable = entry[VALID_BIT] & entry[RDOK_BIT];
        end else begin : g_no_rd_check
            logic unused_rd;
            assign unused_rd   = entry[RDOK_BIT];
            assign leaf_usable = entry[VALID_BIT];
        end
    endgenerate

endmodule

// File: rtl/xlate_walk_fsm.sv
// Module: sequencer of the walk. Issues one read per level, waits for its
// data, and decides the outcome. Assumes the memory takes a read in the
// cycle it is raised and answers it with exactly one mem_rd_valid pulse.
module xlate_walk_fsm (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    rsp_ready,
    input  logic                    mem_rd_valid,
    input  logic                    root_valid,
    input  logic                    leaf_usable,
    output logic                    req_ready,
    output logic                    accept,
    output logic                    load_table,
    output logic                    finish,
    output xlate_pkg::xlate_status_e finish_status,
    output logic                    rd_req,
    output logic                    use_leaf,
    output logic                    rsp_valid
);
    import xlate_pkg::*;

    walk_state_e state_q, state_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Next state and per-state controls.
    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        accept        = 1'b0;
        load_table    = 1'b0;
        finish        = 1'b0;
        finish_status = XS_OK;
        rd_req        = 1'b0;
        use_leaf      = 1'b0;
        rsp_valid     = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = WS_READ_TOP;
                end
            end
            WS_READ_TOP: begin
                rd_req  = 1'b1;
                state_d = WS_WAIT_TOP;
            end
            WS_WAIT_TOP: begin
                if (mem_rd_valid) begin
                    if (root_valid) begin
                        load_table = 1'b1;
                        state_d    = WS_READ_LEAF;
                    end else begin
                        finish        = 1'b1;
                        finish_status = XS_NO_TABLE;
                        state_d       = WS_DONE;
                    end
                end
            end
            WS_READ_LEAF: begin
                rd_req   = 1'b1;
                use_leaf = 1'b1;
                state_d  = WS_WAIT_LEAF;
            end
            WS_WAIT_LEAF: begin
                use_leaf = 1'b1;
                if (mem_rd_valid) begin
                    finish        = 1'b1;
                    finish_status = leaf_usable ? XS_OK : XS_NO_PAGE;
                    state_d       = WS_DONE;
                end
            end
            WS_DONE: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_d = WS_IDLE;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // A read request never lasts two cycles.
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R10

    // Memory data arriving must find the walker waiting for it.
    AST_DATA_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (state_q == WS_WAIT_TOP || state_q == WS_WAIT_LEAF)); // R10

    // Idle and responding never overlap.
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid); // R8

    // A pending response stays until taken.
    AST_RSP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid); // R9

    // After a walk is accepted the walker is busy on the next cycle.
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R8

endmodule

// File: rtl/xlate_walker.sv
// Module: top of the two-level translation walker. Holds the request, the
// second-level table base and the response; the FSM sequences the reads.
// Assumes the memory port has no back-pressure and one read outstanding.
module xlate_walker #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned TOP_W  = 8,
    parameter int unsigned LEAF_W = 12,
    localparam int unsigned OFF_W  = VA_W - TOP_W - LEAF_W,
    localparam int unsigned BASE_W = VA_W - OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] top_base,
    output logic            mem_rd_req,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [VA_W-1:0] mem_rd_data,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [VA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_status
);
    import xlate_pkg::*;

    logic [VA_W-1:0]   vaddr_q;
    logic [VA_W-1:0]   root_q;
    logic [BASE_W-1:0] table_q;
    logic [VA_W-1:0]   paddr_q;
    xlate_status_e     status_q;

    logic              accept, load_table, finish, use_leaf;
    xlate_status_e     finish_status;
    logic              ent_valid, ent_usable;
    logic [BASE_W-1:0] ent_base;
    logic [OFF_W-1:0]  page_off;

    // Walk sequencer.
    xlate_walk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .rsp_ready     (rsp_ready),
        .mem_rd_valid  (mem_rd_valid),
        .root_valid    (ent_valid),
        .leaf_usable   (ent_usable),
        .req_ready     (req_ready),
        .accept        (accept),
        .load_table    (load_table),
        .finish        (finish),
        .finish_status (finish_status),
        .rd_req        (mem_rd_req),
        .use_leaf      (use_leaf),
        .rsp_valid     (rsp_valid)
    );

    // Read address generation for both levels.
    xlate_addr_gen #(
        .VA_W   (VA_W),
        .TOP_W  (TOP_W),
        .LEAF_W (LEAF_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .vaddr      (vaddr_q),
        .root_base  (root_q),
        .table_base (table_q),
        .use_leaf   (use_leaf),
        .rd_addr    (mem_rd_addr),
        .page_off   (page_off)
    );

    // Decoder for the entry on the memory data bus.
    xlate_pte_check #(
        .ENT_W      (VA_W),
        .OFF_W      (OFF_W),
        .REQUIRE_RD (1'b1)
    ) u_pte (
        .entry       (mem_rd_data),
        .is_valid    (ent_valid),
        .leaf_usable (ent_usable),
        .base_field  (ent_base)
    );

    // Capture the request fields when a walk is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            root_q  <= '0;
        end else if (accept) begin
            vaddr_q <= req_vaddr;
            root_q  <= top_base;
        end
    end

    // Capture the second-level table base from a valid root entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          table_q <= '0;
        else if (load_table) table_q <= ent_base;
    end

    // Register the outcome; faults carry a zero address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q  <= '0;
            status_q <= XS_OK;
        end else if (finish) begin
            status_q <= finish_status;
            paddr_q  <= (finish_status == XS_OK) ? {ent_base, page_off} : '0;
        end
    end

    assign rsp_paddr  = paddr_q;
    assign rsp_status = status_q;

    // Faulted walks never expose an address.
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != XS_OK) |-> (rsp_paddr == '0)); // R5

    // A successful result keeps the requested page offset.
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == XS_OK) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R7

    // Status is one of the three defined codes.
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'b11)); // R4

    // A held response keeps its payload.
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> ($stable(rsp_paddr) && $stable(rsp_status))); // R9

    // No memory read while a response is pending.
    AST_NO_RD_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !rsp_valid); // R10

endmodule

// File: tb/xlate_walker_tb_top.sv
// Directed bench for the translation walker: a memory model with programmable
// latency, one task per scenario, each checking its own results.
module xlate_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] top_base = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_status;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    xlate_walker dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .top_base     (top_base),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_paddr    (rsp_paddr),
        .rsp_status   (rsp_status)
    );

    // Sparse table memory and its responder.
    logic [31:0] pmem [int unsigned];
    int          mem_lat = 1;
    logic        pend;
    int          wait_cnt;
    logic [31:0] pend_addr;
    logic [31:0] rd_log [64];
    int          rd_n;
    int          overlap_n;

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend         <= 1'b0;
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
            rd_n         <= 0;
            overlap_n    <= 0;
            wait_cnt     <= 0;
            pend_addr    <= '0;
        end else begin
            mem_rd_valid <= 1'b0;
            if (mem_rd_req) begin
                if (pend) overlap_n <= overlap_n + 1;
                pend      <= 1'b1;
                wait_cnt  <= mem_lat;
                pend_addr <= mem_rd_addr;
                if (rd_n < 64) rd_log[rd_n] <= mem_rd_addr;
                rd_n <= rd_n + 1;
            end else if (pend) begin
                if (wait_cnt == 0) begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= rd_word(pend_addr);
                    pend         <= 1'b0;
                end else begin
                    wait_cnt <= wait_cnt - 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One complete walk with its checks. hold = cycles the response is held off.
    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic [1:0] exp_st, input logic [31:0] exp_pa,
                        input int exp_reads, input logic [31:0] exp_a0,
                        input logic [31:0] exp_a1, input int hold,
                        input bit poke_busy, input string req);
        int          start;
        bit          busy_ok;
        bit          stable_ok;
        logic [31:0] pa0;
        logic [1:0]  st0;
        @(negedge clk);
        start     = rd_n;
        req_vaddr = va;
        top_base  = base;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'hDEAD_BEEF;
        top_base  = 32'h0BAD_0000;
        check(req_ready == 1'b0, "R8", "ready after accept", {31'b0, req_ready}, 32'h0);
        busy_ok = 1'b1;
        for (int i = 0; i < 60 && !rsp_valid; i++) begin
            if (poke_busy) begin
                req_valid = 1'b1;
                req_vaddr = 32'h5555_5555 ^ i;
            end
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (poke_busy)
            check(busy_ok, "R8", "ready stayed low while busy", {31'b0, busy_ok}, 32'h1);
        check(rsp_valid == 1'b1, req, "response arrived", {31'b0, rsp_valid}, 32'h1);
        pa0 = rsp_paddr;
        st0 = rsp_status;
        stable_ok = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_paddr != pa0 || rsp_status != st0) stable_ok = 1'b0;
        end
        if (hold > 0)
            check(stable_ok, "R9", "response held", rsp_paddr, pa0);
        check(rsp_status == exp_st, req, "status", {30'b0, rsp_status}, {30'b0, exp_st});
        check(rsp_paddr == exp_pa, req, "paddr", rsp_paddr, exp_pa);
        check(rd_n - start == exp_reads, req, "read count", rd_n - start, exp_reads);
        check(rd_log[start] == exp_a0, "R2", "root read address", rd_log[start], exp_a0);
        if (exp_reads > 1)
            check(rd_log[start+1] == exp_a1, "R3", "leaf read address", rd_log[start+1], exp_a1);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R8", "idle after take",
              {30'b0, req_ready, rsp_valid}, 32'h2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready in reset", {31'b0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0 && mem_rd_req == 1'b0, "R1", "quiet in reset",
              {30'b0, rsp_valid, mem_rd_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_req == 1'b0, "R1",
              "first cycle after reset", {29'b0, req_ready, rsp_valid, mem_rd_req}, 32'h4);
    endtask

    task automatic t_ok_basic();
        mem_lat = 1;
        walk(32'h1234_5ABC, 32'h0001_0000, 2'b00, 32'hABCD_EABC, 2,
             32'h0001_0012, 32'h0020_0345, 0, 1'b0, "R7");
    endtask

    task automatic t_ok_edges();
        mem_lat = 0;
        walk(32'hFF00_0001, 32'h0001_0000, 2'b00, 32'h0004_2001, 2,
             32'h0001_00FF, 32'h0030_0000, 0, 1'b0, "R7");
        mem_lat = 3;
        walk(32'h20AB_C7FF, 32'h0000_00F0, 2'b00, 32'h1234_57FF, 2,
             32'h0000_0110, 32'h0040_0ABC, 0, 1'b0, "R3");
    endtask

    task automatic t_no_table();
        mem_lat = 2;
        walk(32'h5500_0123, 32'h0001_0000, 2'b01, 32'h0, 1,
             32'h0001_0055, 32'h0, 0, 1'b0, "R4");
    endtask

    task automatic t_page_absent();
        mem_lat = 1;
        walk(32'h1299_9000, 32'h0001_0000, 2'b10, 32'h0, 2,
             32'h0001_0012, 32'h0020_0999, 0, 1'b0, "R5");
    endtask

    task automatic t_page_unreadable();
        mem_lat = 0;
        walk(32'h1288_8FFF, 32'h0001_0000, 2'b10, 32'h0, 2,
             32'h0001_0012, 32'h0020_0888, 0, 1'b0, "R6");
    endtask

    task automatic t_busy_and_hold();
        mem_lat = 4;
        walk(32'h1234_5ABC, 32'h0001_0000, 2'b00, 32'hABCD_EABC, 2,
             32'h0001_0012, 32'h0020_0345, 5, 1'b1, "R8");
        mem_lat = 2;
        walk(32'h5500_0123, 32'h0001_0000, 2'b01, 32'h0, 1,
             32'h0001_0055, 32'h0, 3, 1'b1, "R9");
    endtask

    task automatic t_one_outstanding();
        check(overlap_n == 0, "R10", "reads overlapped", overlap_n, 0);
    endtask

    initial begin
        pmem[32'h0001_0012] = 32'h0020_0001;
        pmem[32'h0020_0345] = 32'hABCD_E003;
        pmem[32'h0001_00FF] = 32'h0030_0001;
        pmem[32'h0030_0000] = 32'h0004_2003;
        pmem[32'h0000_0110] = 32'h0040_0001;
        pmem[32'h0040_0ABC] = 32'h1234_5003;
        pmem[32'h0001_0055] = 32'hFFFF_F000;
        pmem[32'h0020_0999] = 32'h7777_7002;
        pmem[32'h0020_0888] = 32'h6666_6001;
        t_reset();
        t_ok_basic();
        t_ok_edges();
        t_no_table();
        t_page_absent();
        t_page_unreadable();
        t_busy_and_hold();
        t_one_outstanding();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule